// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a multi-channel DMA controller. A simple request/response register bus reaches a small set of global words and a repeated per-channel window. Each channel window holds a control/status word, a transfer size, source and destination addresses with their address-wrap masks, a descriptor pointer and a software pointer. Every stored value is also driven out as a parallel port, so the channel engines can use their configuration without going through the bus.

The channel engines report events through single-cycle pulses: error, chunk-complete interrupt, transfer-complete interrupt and error interrupt. Each pulse sets a sticky flag in the channel's control/status word. A bus read of that word returns its current contents and clears the four sticky flags in the same step. Software writes reach only the control field of the word. The flags and the live busy indication cannot be changed by software. Bus responses are registered and arrive one cycle after the request. Misaligned, undefined or out-of-range offsets return an error instead of data.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, except the source-mask and destination-mask words of every channel, which read 0xFFFFFFFC.
- R2: Each request cycle is answered by `rsp_ack` high in exactly the next cycle and in no other. `rsp_rdata` is the addressed value for a good read, and zero for writes and for failed accesses.
- R3: A request whose offset has bits [1:0] non-zero answers with `rsp_err` and changes no register.
- R4: The global words sit at these offsets: control 0x00, interrupt mask A 0x04, interrupt mask B 0x08, interrupt source A 0x0C, interrupt source B 0x10. All five are fully writable. Offsets 0x14 to 0x1C answer with `rsp_err`, and a write to them changes nothing.
- R5: At offset 0x20 and above, the channel number is (offset − 0x20) / 0x20 and the word is selected by offset bits [4:2]. Offsets at or above 0x120 (channel 8 and up) answer with `rsp_err`.
- R6: The channel words are at these window offsets: size 0x04, source 0x08, source mask 0x0C, destination 0x10, destination mask 0x14, descriptor 0x18, software pointer 0x1C. All are fully writable and read back.
- R7: A write to the channel control/status word (window offset 0x00) changes only bits [10:0]. Bits [31:11] keep their hardware-driven values, so a write cannot set or clear a status flag.
- R8: In the control/status word, bit 12 shows the channel's `hw_busy` input live. Pulses on `evt_err`, `evt_chunk`, `evt_done` and `evt_errint` set sticky bits 13, 14, 15 and 16 respectively.
- R9: A successful read of a channel control/status word returns its value, then clears bits 13 to 16 of that channel only.
- R10: When a set pulse arrives in the same cycle as a clearing read of the same channel, the flag is set after that cycle. The read returns the flag's value from before that cycle.
- R11: The per-channel and global output ports always equal the corresponding stored register, with `ch_ctrl` equal to control/status bits [10:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Previous request was misaligned or undecoded |
| hw_busy | input | NCH | Live busy level per channel |
| evt_err | input | NCH | Error flag set pulse per channel |
| evt_chunk | input | NCH | Chunk-complete interrupt set pulse |
| evt_done | input | NCH | Transfer-complete interrupt set pulse |
| evt_errint | input | NCH | Error interrupt set pulse |
| ch_ctrl | output | NCH x 11 | Control field of each channel |
| ch_size | output | NCH x 32 | Size word per channel |
| ch_src | output | NCH x 32 | Source address per channel |
| ch_src_msk | output | NCH x 32 | Source address mask per channel |
| ch_dst | output | NCH x 32 | Destination address per channel |
| ch_dst_msk | output | NCH x 32 | Destination address mask per channel |
| ch_desc | output | NCH x 32 | Descriptor pointer per channel |
| ch_swptr | output | NCH x 32 | Software pointer per channel |
| glb_ctrl | output | 32 | Global control word |
| glb_msk_a | output | 32 | Interrupt mask A |
| glb_msk_b | output | 32 | Interrupt mask B |
| glb_src_a | output | 32 | Interrupt source A |
| glb_src_b | output | 32 | Interrupt source B |

## Verification
Two functions can fall on the same clock edge: a hardware set pulse for a channel's sticky flag, and the software read that clears the flags of that same word. The bench raises the event pulse in exactly the cycle that carries the control/status read request. It does this twice: once with the flag previously clear, and once with the flag already set. The returned word must show the flag's value from before the edge. A second read must then show the flag set, and a third read must show it cleared. This proves that the set took priority and that no event was lost.

// File: rtl/dma_rb_pkg.sv
// Package: shared constants and register selectors for the DMA register bank.
// Assumes a 32-bit data bus and a channel window of eight 32-bit words.
package dma_rb_pkg;
    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 32;
    localparam int WIN_LG    = $clog2(WIN_BYTES);
    localparam int GLB_REGS  = 5;
    localparam int CTRL_W    = 11;
    localparam int BUSY_BIT  = 12;
    localparam int STAT_LSB  = 13;
    localparam int STAT_W    = 4;
    localparam logic [DATA_W-1:0] MASK_RST = 32'hFFFF_FFFC;

    typedef enum logic [2:0] {
        CR_CSR, CR_SIZE, CR_SRC, CR_SRC_MSK, CR_DST, CR_DST_MSK, CR_DESC, CR_SWPTR
    } chreg_e;

    typedef enum logic [2:0] {
        GR_CTRL, GR_MSK_A, GR_MSK_B, GR_SRC_A, GR_SRC_B
    } glreg_e;
endpackage

// File: rtl/dma_rb_decode.sv
// Module: combinational offset decoder.
// Splits a byte offset into global or channel space. Flags misaligned,
// undefined-global and out-of-range offsets. Assumes CH_BASE is a multiple
// of the window size and NCH is a power of two.
module dma_rb_decode
    import dma_rb_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CH_BASE = 32,
    parameter int ADDR_W  = 9,
    localparam int CH_W   = $clog2(NCH),
    localparam int HI_W   = ADDR_W - WIN_LG
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_glb,
    output logic [CH_W-1:0]   ch_idx,
    output logic [2:0]        word_sel,
    output logic              bad
);
    localparam int BASE_BLK = CH_BASE / WIN_BYTES;

    logic [HI_W-1:0] blk;
    int              ch_num;

    // Purpose: classify the offset and derive channel number and word index.
    always_comb begin
        blk      = addr[ADDR_W-1:WIN_LG];
        word_sel = addr[WIN_LG-1:2];
        is_glb   = int'(blk) < BASE_BLK;
        ch_num   = int'(blk) - BASE_BLK;
        ch_idx   = CH_W'(ch_num);
        if (addr[1:0] != 2'b00)
            bad = 1'b1;
        else if (is_glb)
            bad = int'(word_sel) >= GLB_REGS;
        else
            bad = ch_num >= NCH;
    end
endmodule

// File: rtl/dma_rb_global.sv
// Module: the five global words, all fully writable by software.
// Assumes the caller asserts wr_en only for a decoded, legal global word.
module dma_rb_global
    import dma_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] msk_a_o,
    output logic [DATA_W-1:0] msk_b_o,
    output logic [DATA_W-1:0] src_a_o,
    output logic [DATA_W-1:0] src_b_o
);
    logic [DATA_W-1:0] ctrl_q, msk_a_q, msk_b_q, src_a_q, src_b_q;

    // Purpose: store software writes to the selected global word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            msk_a_q <= '0;
            msk_b_q <= '0;
            src_a_q <= '0;
            src_b_q <= '0;
        end else if (wr_en) begin
            case (sel)
                GR_CTRL:  ctrl_q  <= wdata;
                GR_MSK_A: msk_a_q <= wdata;
                GR_MSK_B: msk_b_q <= wdata;
                GR_SRC_A: src_a_q <= wdata;
                GR_SRC_B: src_b_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: select the global word for read-back.
    always_comb begin
        case (sel)
            GR_CTRL:  rdata = ctrl_q;
            GR_MSK_A: rdata = msk_a_q;
            GR_MSK_B: rdata = msk_b_q;
            GR_SRC_A: rdata = src_a_q;
            GR_SRC_B: rdata = src_b_q;
            default:  rdata = '0;
        endcase
    end

    assign ctrl_o  = ctrl_q;
    assign msk_a_o = msk_a_q;
    assign msk_b_o = msk_b_q;
    assign src_a_o = src_a_q;
    assign src_b_o = src_b_q;
endmodule

// File: rtl/dma_rb_channel.sv
// Module: the register window of one DMA channel.
// The control/status word combines a writable control field, a live busy
// bit and four sticky flags. The flags are set by engine pulses and cleared
// by a bus read; a set in the same cycle wins. Assumes wr_en and rd_csr are
// already qualified by the decoder for this channel.
module dma_rb_channel
    import dma_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_csr,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy_i,
    input  logic [STAT_W-1:0] set_vec,
    output logic [DATA_W-1:0] rdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] size_o,
    output logic [DATA_W-1:0] src_o,
    output logic [DATA_W-1:0] src_msk_o,
    output logic [DATA_W-1:0] dst_o,
    output logic [DATA_W-1:0] dst_msk_o,
    output logic [DATA_W-1:0] desc_o,
    output logic [DATA_W-1:0] swptr_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] regs_q [8];
    logic [DATA_W-1:0] csr_val;

    // Purpose: control field takes only its writable bits from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en && sel == CR_CSR)
            ctrl_q <= wdata[CTRL_W-1:0];
    end

    // Purpose: sticky flags, cleared by a CSR read, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (rd_csr ? '0 : stat_q) | set_vec;
    end

    // Purpose: plain data words of the window; the masks reset to word-aligned all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 8; r++)
                regs_q[r] <= (r == CR_SRC_MSK || r == CR_DST_MSK) ? MASK_RST : '0;
        end else if (wr_en) begin
            for (int r = 1; r < 8; r++)
                if (sel == 3'(r))
                    regs_q[r] <= wdata;
        end
    end

    // Purpose: assemble the control/status word and pick the read word.
    always_comb begin
        csr_val                      = '0;
        csr_val[CTRL_W-1:0]          = ctrl_q;
        csr_val[BUSY_BIT]            = busy_i;
        csr_val[STAT_LSB +: STAT_W]  = stat_q;
        rdata = (sel == CR_CSR) ? csr_val : regs_q[sel];
    end

    assign ctrl_o    = ctrl_q;
    assign size_o    = regs_q[CR_SIZE];
    assign src_o     = regs_q[CR_SRC];
    assign src_msk_o = regs_q[CR_SRC_MSK];
    assign dst_o     = regs_q[CR_DST];
    assign dst_msk_o = regs_q[CR_DST_MSK];
    assign desc_o    = regs_q[CR_DESC];
    assign swptr_o   = regs_q[CR_SWPTR];

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

    // R9
    clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_csr && set_vec == '0) |=> (stat_q == '0));

    // R7
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_csr && set_vec == '0) |=> $stable(stat_q));
endmodule

// File: rtl/dma_regbank.sv
// Module: top of the DMA register bank.
// Decodes the bus request, steers writes and clearing reads to the global
// block or to one channel window, and registers the response one cycle
// later. Assumes one request per cycle and NCH a power of two.
module dma_regbank
    import dma_rb_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CH_BASE = 32,
    parameter int ADDR_W  = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          rsp_ack,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic                          rsp_err,
    input  logic [NCH-1:0]                hw_busy,
    input  logic [NCH-1:0]                evt_err,
    input  logic [NCH-1:0]                evt_chunk,
    input  logic [NCH-1:0]                evt_done,
    input  logic [NCH-1:0]                evt_errint,
    output logic [NCH-1:0][CTRL_W-1:0]    ch_ctrl,
    output logic [NCH-1:0][DATA_W-1:0]    ch_size,
    output logic [NCH-1:0][DATA_W-1:0]    ch_src,
    output logic [NCH-1:0][DATA_W-1:0]    ch_src_msk,
    output logic [NCH-1:0][DATA_W-1:0]    ch_dst,
    output logic [NCH-1:0][DATA_W-1:0]    ch_dst_msk,
    output logic [NCH-1:0][DATA_W-1:0]    ch_desc,
    output logic [NCH-1:0][DATA_W-1:0]    ch_swptr,
    output logic [DATA_W-1:0]             glb_ctrl,
    output logic [DATA_W-1:0]             glb_msk_a,
    output logic [DATA_W-1:0]             glb_msk_b,
    output logic [DATA_W-1:0]             glb_src_a,
    output logic [DATA_W-1:0]             glb_src_b
);
    localparam int CH_W   = $clog2(NCH);
    localparam int CH_END = CH_BASE + NCH * WIN_BYTES;

    logic              dec_glb;
    logic [CH_W-1:0]   dec_ch;
    logic [2:0]        dec_sel;
    logic              dec_bad;
    logic              acc_ok;
    logic              glb_wr;
    logic [DATA_W-1:0] glb_rdata;
    logic [DATA_W-1:0] ch_rdata [NCH];
    logic [DATA_W-1:0] rd_mux;

    dma_rb_decode #(.NCH(NCH), .CH_BASE(CH_BASE), .ADDR_W(ADDR_W)) u_dec (
        .addr     (req_addr),
        .is_glb   (dec_glb),
        .ch_idx   (dec_ch),
        .word_sel (dec_sel),
        .bad      (dec_bad)
    );

    assign acc_ok = req_valid && !dec_bad;
    assign glb_wr = acc_ok && req_write && dec_glb;

    dma_rb_global u_glb (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (glb_wr),
        .sel     (dec_sel),
        .wdata   (req_wdata),
        .rdata   (glb_rdata),
        .ctrl_o  (glb_ctrl),
        .msk_a_o (glb_msk_a),
        .msk_b_o (glb_msk_b),
        .src_a_o (glb_src_a),
        .src_b_o (glb_src_b)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = acc_ok && !dec_glb && dec_ch == CH_W'(g);

        dma_rb_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (hit && req_write),
            .rd_csr    (hit && !req_write && dec_sel == CR_CSR),
            .sel       (dec_sel),
            .wdata     (req_wdata),
            .busy_i    (hw_busy[g]),
            .set_vec   ({evt_errint[g], evt_done[g], evt_chunk[g], evt_err[g]}),
            .rdata     (ch_rdata[g]),
            .ctrl_o    (ch_ctrl[g]),
            .size_o    (ch_size[g]),
            .src_o     (ch_src[g]),
            .src_msk_o (ch_src_msk[g]),
            .dst_o     (ch_dst[g]),
            .dst_msk_o (ch_dst_msk[g]),
            .desc_o    (ch_desc[g]),
            .swptr_o   (ch_swptr[g])
        );
    end

    // Purpose: choose the global word or the addressed channel's word.
    always_comb begin
        rd_mux = dec_glb ? glb_rdata : ch_rdata[dec_ch];
    end

    // Purpose: register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ack   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ack   <= req_valid;
            rsp_err   <= req_valid && dec_bad;
            rsp_rdata <= (acc_ok && !req_write) ? rd_mux : '0;
        end
    end

    // R2
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack);

    // R2
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack);

    // R3
    misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == '0));

    // R5
    range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_addr) >= CH_END) |=> rsp_err);
endmodule

// File: tb/dma_regbank_tb.sv
`timescale 1ns/1ps
module dma_regbank_tb;
    localparam int NCH = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [8:0]             req_addr = '0;
    logic [31:0]            req_wdata = '0;
    logic                   rsp_ack;
    logic [31:0]            rsp_rdata;
    logic                   rsp_err;
    logic [NCH-1:0]         hw_busy = '0;
    logic [NCH-1:0]         evt_err = '0;
    logic [NCH-1:0]         evt_chunk = '0;
    logic [NCH-1:0]         evt_done = '0;
    logic [NCH-1:0]         evt_errint = '0;
    logic [NCH-1:0][10:0]   ch_ctrl;
    logic [NCH-1:0][31:0]   ch_size, ch_src, ch_src_msk, ch_dst, ch_dst_msk, ch_desc, ch_swptr;
    logic [31:0]            glb_ctrl, glb_msk_a, glb_msk_b, glb_src_a, glb_src_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_regbank #(.NCH(NCH), .CH_BASE(32), .ADDR_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .hw_busy(hw_busy), .evt_err(evt_err), .evt_chunk(evt_chunk),
        .evt_done(evt_done), .evt_errint(evt_errint),
        .ch_ctrl(ch_ctrl), .ch_size(ch_size), .ch_src(ch_src), .ch_src_msk(ch_src_msk),
        .ch_dst(ch_dst), .ch_dst_msk(ch_dst_msk), .ch_desc(ch_desc), .ch_swptr(ch_swptr),
        .glb_ctrl(glb_ctrl), .glb_msk_a(glb_msk_a), .glb_msk_b(glb_msk_b),
        .glb_src_a(glb_src_a), .glb_src_b(glb_src_b)
    );

    typedef struct packed {
        logic        wr;
        logic [8:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  rq;
    } vec_t;

    // Channel c, window offset w: address 0x20 + c*0x20 + w.
    localparam vec_t VECS [21] = '{
        '{1'b1, 9'h024, 32'h0000_1234, 32'h0, 1'b0, 4'd6},  // R6 ch0 size write
        '{1'b0, 9'h024, 32'h0,         32'h0000_1234, 1'b0, 4'd6},
        '{1'b0, 9'h08C, 32'h0,         32'hFFFF_FFFC, 1'b0, 4'd1},  // R1 ch3 src mask
        '{1'b0, 9'h114, 32'h0,         32'hFFFF_FFFC, 1'b0, 4'd1},  // R1 ch7 dst mask
        '{1'b1, 9'h11C, 32'hDEAD_BEEF, 32'h0, 1'b0, 4'd6},
        '{1'b0, 9'h11C, 32'h0,         32'hDEAD_BEEF, 1'b0, 4'd6},
        '{1'b0, 9'h03C, 32'h0,         32'h0, 1'b0, 4'd5},          // R5 no alias ch0
        '{1'b1, 9'h004, 32'hA5A5_0F0F, 32'h0, 1'b0, 4'd4},          // R4
        '{1'b0, 9'h004, 32'h0,         32'hA5A5_0F0F, 1'b0, 4'd4},
        '{1'b1, 9'h010, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd4},
        '{1'b0, 9'h010, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd4},
        '{1'b0, 9'h014, 32'h0,         32'h0, 1'b1, 4'd4},          // illegal global
        '{1'b1, 9'h026, 32'hFFFF_0000, 32'h0, 1'b1, 4'd3},          // R3 misaligned
        '{1'b0, 9'h024, 32'h0,         32'h0000_1234, 1'b0, 4'd3},
        '{1'b0, 9'h120, 32'h0,         32'h0, 1'b1, 4'd5},          // out of range
        '{1'b1, 9'h0A0, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd7},          // R7 ch4 csr
        '{1'b0, 9'h0A0, 32'h0,         32'h0000_07FF, 1'b0, 4'd7},
        '{1'b1, 9'h0D8, 32'h1000_0040, 32'h0, 1'b0, 4'd6},          // ch5 desc
        '{1'b0, 9'h0D8, 32'h0,         32'h1000_0040, 1'b0, 4'd6},
        '{1'b1, 9'h018, 32'h1234_5678, 32'h0, 1'b1, 4'd4},          // illegal write
        '{1'b0, 9'h000, 32'h0,         32'h0, 1'b0, 4'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives one request and samples its response at the next negedge.
    task automatic xfer(input logic wr, input logic [8:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er, output logic ak);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata; er = rsp_err; ak = rsp_ack;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er; logic ak;
        xfer(1'b0, a, 32'h0, rd, er, ak);
        chk(tag, rd, exp);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er; logic ak;
        xfer(1'b1, a, d, rd, er, ak);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic er; logic ak;
        repeat (3) @(negedge clk);
        chk("R2 ack low in reset", {31'd0, rsp_ack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values over the whole bank
        for (int g = 0; g < 5; g++) rd_chk("R1 global reset", 9'(g * 4), 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rd_chk("R1 csr reset",      9'(32 + c * 32 + 0),  32'h0);
            rd_chk("R1 size reset",     9'(32 + c * 32 + 4),  32'h0);
            rd_chk("R1 src mask reset", 9'(32 + c * 32 + 12), 32'hFFFF_FFFC);
            rd_chk("R1 dst mask reset", 9'(32 + c * 32 + 20), 32'hFFFF_FFFC);
            chk("R11 src mask port", ch_src_msk[c], 32'hFFFF_FFFC);
        end

        // Vector table
        for (int i = 0; i < 21; i++) begin
            xfer(VECS[i].wr, VECS[i].addr, VECS[i].wd, rd, er, ak);
            checks++;
            if (rd !== VECS[i].exp || er !== VECS[i].err || ak !== 1'b1) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual data 0x%08h err %b ack %b expected data 0x%08h err %b ack 1",
                         VECS[i].rq, i, rd, er, ak, VECS[i].exp, VECS[i].err);
            end
        end
        chk("R11 ctrl port ch4", 32'(ch_ctrl[4]), 32'h7FF);
        chk("R11 glb mask A port", glb_msk_a, 32'hA5A5_0F0F);
        chk("R11 glb src B port", glb_src_b, 32'hFFFF_FFFF);

        // R2: ack only for the request cycle, write returns zero data
        xfer(1'b1, 9'h048, 32'h2000_0000, rd, er, ak);
        chk("R2 write ack", {31'd0, ak}, 32'd1);
        chk("R2 write data zero", rd, 32'h0);
        @(negedge clk);
        chk("R2 idle no ack", {31'd0, rsp_ack}, 32'd0);
        chk("R11 src port ch1", ch_src[1], 32'h2000_0000);

        // R3: misaligned read errors with zero data
        xfer(1'b0, 9'h049, 32'h0, rd, er, ak);
        chk("R3 misaligned read err", {31'd0, er}, 32'd1);
        chk("R3 misaligned read data", rd, 32'h0);

        // R8: done pulse and live busy on channel 2 (csr at 0x60)
        evt_done[2] = 1'b1; @(negedge clk); evt_done[2] = 1'b0;
        hw_busy[2] = 1'b1;
        rd_chk("R8 done flag and busy", 9'h060, 32'h0000_9000);
        rd_chk("R9 done cleared busy live", 9'h060, 32'h0000_1000);
        hw_busy[2] = 1'b0;
        rd_chk("R8 busy follows input", 9'h060, 32'h0);

        // R9: three flags on channel 1 (csr at 0x40), cleared by a single read
        evt_err[1] = 1'b1; evt_chunk[1] = 1'b1; evt_errint[1] = 1'b1;
        @(negedge clk);
        evt_err[1] = 1'b0; evt_chunk[1] = 1'b0; evt_errint[1] = 1'b0;
        evt_done[3] = 1'b1; @(negedge clk); evt_done[3] = 1'b0;
        rd_chk("R9 flags visible", 9'h040, 32'h0001_6000);
        rd_chk("R9 flags cleared", 9'h040, 32'h0);
        rd_chk("R9 other channel untouched", 9'h080, 32'h0000_8000);

        // R7: writes cannot clear flags, only bits [10:0] land
        evt_done[6] = 1'b1; @(negedge clk); evt_done[6] = 1'b0;
        wr(9'h0E0, 32'hFFFF_F155);
        chk("R11 ctrl port ch6", 32'(ch_ctrl[6]), 32'h155);
        rd_chk("R7 flag survives write", 9'h0E0, 32'h0000_8155);

        // R10: set pulse in the same cycle as the clearing read, flag previously clear
        evt_chunk[0] = 1'b1;
        xfer(1'b0, 9'h020, 32'h0, rd, er, ak);
        evt_chunk[0] = 1'b0;
        chk("R10 read shows prior value", rd, 32'h0);
        rd_chk("R10 set won over clear", 9'h020, 32'h0000_4000);
        rd_chk("R10 later read clears", 9'h020, 32'h0);

        // R10: same flag already set and pulsed again during the read (channel 3)
        evt_done[3] = 1'b1; @(negedge clk); evt_done[3] = 1'b0;
        evt_done[3] = 1'b1;
        xfer(1'b0, 9'h080, 32'h0, rd, er, ak);
        evt_done[3] = 1'b0;
        chk("R10 read returns set flag", rd, 32'h0000_8000);
        rd_chk("R10 flag kept by new event", 9'h080, 32'h0000_8000);
        rd_chk("R10 flag cleared afterwards", 9'h080, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule